// File: doc/BRIEF.md
# Balanced Ternary Single-Trit Function Unit

This block applies one of a small set of single-trit functions to an input trit. A trit holds -1, 0 or +1 and travels on a 2-bit binary bus. Every function is a three-way selection in which the input trit is the selector. The block places three constant trits on the data legs of that selector, and each function uses its own set of constants.

A 3-bit function code chooses the function: identity, wrapping increment, wrapping decrement, clamp-below-at-zero (max with 0), clamp-above-at-zero (min with 0), or a programmable mode. In programmable mode, three trits supplied on ports feed the data legs, so any mapping from one trit to one trit can be built. The unit is purely combinational. An illegal trit code on an input that is in use, or an unassigned function code, forces the output to zero and raises an error flag.

Top module: `tern_unary_unit`

## Requirements
- R1: Trits are encoded 2'b11 = -1, 2'b00 = 0, 2'b01 = +1; 2'b10 is illegal and `y_trit` never carries 2'b10.
- R2: Function code 3'd0 (identity) gives `y_trit` equal to `a_trit` for every legal `a_trit`.
- R3: Function code 3'd1 (increment) maps -1 to 0, 0 to +1 and +1 to -1.
- R4: Function code 3'd2 (decrement) maps -1 to +1, 0 to -1 and +1 to 0.
- R5: Function code 3'd3 (max with zero) gives 0 for -1 and passes 0 and +1 unchanged.
- R6: Function code 3'd4 (min with zero) gives 0 for +1 and passes -1 and 0 unchanged.
- R7: Function code 3'd5 (programmable) outputs `k_neg` when `a_trit` is -1, `k_zero` when it is 0 and `k_pos` when it is +1.
- R8: When `a_trit` holds the illegal code, `y_trit` is 0 and `err` is 1, whatever the function code.
- R9: In programmable mode, an illegal code on any of `k_neg`, `k_zero` or `k_pos` forces `y_trit` to 0 and sets `err`. In every other mode these three ports are ignored and affect neither output.
- R10: Function codes 3'd6 and 3'd7 are unassigned: `y_trit` is 0 and `err` is 1.
- R11: With legal inputs and an assigned function code, `err` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn_sel | input | 3 | Function code |
| a_trit | input | 2 | Operand trit, also the selector |
| k_neg | input | 2 | Programmable result for a -1 operand |
| k_zero | input | 2 | Programmable result for a 0 operand |
| k_pos | input | 2 | Programmable result for a +1 operand |
| y_trit | output | 2 | Result trit |
| err | output | 1 | Illegal code or unassigned function |

## Verification
Function evaluation and error detection can both apply in the same cycle. This happens when an illegal operand code, an illegal programmable constant, or an unassigned function code arrives while a function is selected. The bench provokes this by sweeping every 2-bit pattern of the operand and of all three constants under every one of the eight function codes, illegal patterns included. A behavioural integer model decides in each case whether the error has priority, in which case the output must be 0 with the flag raised. Otherwise the arithmetic result must appear, with the constants having no effect outside programmable mode.

// File: rtl/tern_unary_unit.sv
module tern_unary_unit (
  input  logic [2:0] fn_sel,
  input  logic [1:0] a_trit,
  input  logic [1:0] k_neg,
  input  logic [1:0] k_zero,
  input  logic [1:0] k_pos,
  output logic [1:0] y_trit,
  output logic       err
);
  localparam logic [1:0] T_NEG  = 2'b11;
  localparam logic [1:0] T_ZERO = 2'b00;
  localparam logic [1:0] T_POS  = 2'b01;
  localparam logic [1:0] T_BAD  = 2'b10;

  localparam logic [2:0] FN_IDENT = 3'd0;
  localparam logic [2:0] FN_INC   = 3'd1;
  localparam logic [2:0] FN_DEC   = 3'd2;
  localparam logic [2:0] FN_MAX0  = 3'd3;
  localparam logic [2:0] FN_MIN0  = 3'd4;
  localparam logic [2:0] FN_PROG  = 3'd5;

  logic [1:0] leg_n, leg_z, leg_p;
  logic [1:0] mux_y;
  logic       fn_bad, a_bad, k_bad;

  always_comb begin
    leg_n = T_ZERO;
    leg_z = T_ZERO;
    leg_p = T_ZERO;
    fn_bad = 1'b0;
    case (fn_sel)
      FN_IDENT: begin leg_n = T_NEG;  leg_z = T_ZERO; leg_p = T_POS;  end
      FN_INC:   begin leg_n = T_ZERO; leg_z = T_POS;  leg_p = T_NEG;  end
      FN_DEC:   begin leg_n = T_POS;  leg_z = T_NEG;  leg_p = T_ZERO; end
      FN_MAX0:  begin leg_n = T_ZERO; leg_z = T_ZERO; leg_p = T_POS;  end
      FN_MIN0:  begin leg_n = T_NEG;  leg_z = T_ZERO; leg_p = T_ZERO; end
      FN_PROG:  begin leg_n = k_neg;  leg_z = k_zero; leg_p = k_pos;  end
      default:  fn_bad = 1'b1;
    endcase
  end

  always_comb begin
    case (a_trit)
      T_NEG:   mux_y = leg_n;
      T_ZERO:  mux_y = leg_z;
      T_POS:   mux_y = leg_p;
      default: mux_y = T_ZERO;
    endcase
  end

  assign a_bad  = (a_trit == T_BAD);
  assign k_bad  = (fn_sel == FN_PROG) &&
                  ((k_neg == T_BAD) || (k_zero == T_BAD) || (k_pos == T_BAD));
  assign err    = fn_bad | a_bad | k_bad;
  assign y_trit = err ? T_ZERO : mux_y;
endmodule

module tern_unary_unit_chk (
  input logic [2:0] fn_sel,
  input logic [1:0] a_trit,
  input logic [1:0] k_neg,
  input logic [1:0] k_zero,
  input logic [1:0] k_pos,
  input logic [1:0] y_trit,
  input logic       err
);
  logic legal_in;
  assign legal_in = (a_trit != 2'b10) && !err;

  always_comb begin
    assert_no_bad_code_R1: assert (y_trit != 2'b10);
    if (a_trit == 2'b10)
      assert_bad_operand_R8: assert (err && y_trit == 2'b00);
    if (fn_sel > 3'd5)
      assert_unassigned_R10: assert (err && y_trit == 2'b00);
    if (legal_in && fn_sel == 3'd0)
      assert_identity_R2: assert (y_trit == a_trit);
    if (legal_in && fn_sel == 3'd1)
      assert_inc_wrap_R3: assert ((a_trit == 2'b01) ? (y_trit == 2'b11)
                                  : (y_trit == a_trit + 2'b01));
    if (legal_in && fn_sel == 3'd2)
      assert_dec_wrap_R4: assert ((a_trit == 2'b11) ? (y_trit == 2'b01)
                                  : (y_trit == a_trit - 2'b01));
    if (legal_in && fn_sel == 3'd3)
      assert_max0_R5: assert (y_trit != 2'b11);
    if (legal_in && fn_sel == 3'd4)
      assert_min0_R6: assert (y_trit != 2'b01);
    if (legal_in && fn_sel == 3'd5 && a_trit == 2'b11)
      assert_prog_route_R7: assert (y_trit == k_neg);
    if (fn_sel != 3'd5 && fn_sel < 3'd6 && a_trit != 2'b10)
      assert_consts_ignored_R9: assert (!err);
  end
endmodule

bind tern_unary_unit tern_unary_unit_chk u_chk (.*);

// File: tb/tern_unary_unit_tb.sv
module tern_unary_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0] fn_sel;
  logic [1:0] a_trit, k_neg, k_zero, k_pos;
  logic [1:0] y_trit;
  logic       err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  tern_unary_unit u_dut (
    .fn_sel(fn_sel), .a_trit(a_trit), .k_neg(k_neg), .k_zero(k_zero),
    .k_pos(k_pos), .y_trit(y_trit), .err(err)
  );

  function automatic int dec_t(input logic [1:0] c);
    case (c)
      2'b11: return -1;
      2'b00: return 0;
      2'b01: return 1;
      default: return 9;
    endcase
  endfunction

  function automatic logic [1:0] enc_t(input int v);
    if (v < 0) return 2'b11;
    if (v > 0) return 2'b01;
    return 2'b00;
  endfunction

  task automatic apply_and_check(input logic [2:0] f, input logic [1:0] a,
                                 input logic [1:0] kn, input logic [1:0] kz,
                                 input logic [1:0] kp);
    int av, rv;
    bit e;
    string tag;
    @(posedge clk);
    fn_sel = f; a_trit = a; k_neg = kn; k_zero = kz; k_pos = kp;
    @(negedge clk);
    av = dec_t(a);
    e = 1'b0; rv = 0;
    if (av == 9) begin e = 1'b1; tag = "R8"; end
    else if (f > 3'd5) begin e = 1'b1; tag = "R10"; end
    else if (f == 3'd5 && (dec_t(kn) == 9 || dec_t(kz) == 9 || dec_t(kp) == 9)) begin
      e = 1'b1; tag = "R9";
    end else begin
      case (f)
        3'd0: begin rv = av; tag = "R2"; end
        3'd1: begin rv = ((av + 2) % 3) - 1; tag = "R3"; end
        3'd2: begin rv = ((av + 3) % 3) - 1; tag = "R4"; end
        3'd3: begin rv = (av > 0) ? av : 0; tag = "R5"; end
        3'd4: begin rv = (av < 0) ? av : 0; tag = "R6"; end
        default: begin
          rv = (av < 0) ? dec_t(kn) : (av == 0) ? dec_t(kz) : dec_t(kp);
          tag = "R7";
        end
      endcase
      if (f != 3'd5 && (kn == 2'b10 || kz == 2'b10 || kp == 2'b10)) tag = "R9";
    end
    checks++;
    if (y_trit !== enc_t(rv) || err !== e || y_trit === 2'b10) begin
      errors++;
      $display("FAIL %s fn=%0d a=%b k=%b%b%b: y=%b err=%b expected y=%b err=%b (R1 R11)",
               tag, f, a, kn, kz, kp, y_trit, err, enc_t(rv), e);
    end
  endtask

  initial begin
    fn_sel = 3'd0; a_trit = 2'b00; k_neg = 2'b00; k_zero = 2'b00; k_pos = 2'b00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (y_trit !== 2'b00 || err !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset state: y=%b err=%b expected y=00 err=0", y_trit, err);
    end
    for (int f = 0; f < 8; f++)
      for (int a = 0; a < 4; a++)
        for (int k = 0; k < 64; k++)
          apply_and_check(3'(f), 2'(a), 2'(k >> 4), 2'(k >> 2), 2'(k));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual hung expected finished");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule